// File: doc/BRIEF.md
# Windowed Signal Activity Monitor

This block observes a bank of 128 internal idle or activity lines, arranged as four groups of 32, and measures how busy four chosen lines are over a window of programmable length. Each of four channels picks its own line and counts either rising edges, falling edges, cycles spent high or cycles spent low. Counting advances on "ticks": every system clock in fast mode, or only on cycles where an external slow timebase pulse is present in slow mode.

When the programmed number of ticks has elapsed, each channel's count is copied into a result register that software reads, the counters restart from zero on the following tick, and a status flag is raised. The flag drives an interrupt line through a mask bit, and software clears it by writing a one. All configuration and readback go through a simple word-addressed register port with single-cycle writes and combinational reads. Software turns the block off by clearing the enable bit, then masks and clears the flag.

Top module: `activity_window_monitor`

## Requirements
- R1: Channel c monitors line sig_i[group*32+index], where the selector register (address 2) holds one 7-bit selector per channel at bits [8c+6:8c], with bits [8c+4:8c] the index and bits [8c+6:8c+5] the group.
- R2: Control register (address 0): bit 0 enables, bit 1 selects fast mode (1 = a tick on every clock, 0 = a tick only on cycles with slow_tick_i high), and bits [2c+5:2c+4] hold the mode of channel c: 0 rising edges, 1 falling edges, 2 high cycles, 3 low cycles.
- R3: In edge modes, a tick counts one when the line value at that tick differs in the configured direction from the value at the previous tick. The first tick after enabling compares against the value present on the edge where enable took effect.
- R4: In level modes, a tick counts one when the line equals the configured level at that tick.
- R5: With window length L (address 1), the L-th tick of a window ends it, and the value of that tick is included in the result. The next window counts ticks L+1 to 2L, with no tick lost or counted twice. A length of 0 gives one-tick windows.
- R6: Result registers at addresses 8 to 11 (channel 0 to 3) keep their value until the next window ends, whether or not the flag is cleared. Writes to them have no effect.
- R7: Status bit 2 (address 4) sets when a window ends. Writing a word with bit 2 set clears it, and writing 0 leaves it unchanged. A window end in the same cycle as a clear leaves it set.
- R8: irq_o is high exactly when status bit 2 is set and mask bit 2 (address 3) is clear.
- R9: While enable is low, the window and channel counters hold at zero, no window ends, and the results and status are left unchanged. Setting enable starts a fresh window.
- R10: After reset, every register reads 0 except the mask register, which reads 4 (masked), and irq_o is low.
- R11: In slow mode, lines are sampled and windows advance only on slow_tick_i cycles, so activity between ticks is invisible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| sig_i | input | 128 | Monitored lines, group-major |
| slow_tick_i | input | 1 | Slow timebase pulse, one clock wide |
| irq_o | output | 1 | Window-done interrupt |

## Verification
The bench uses the default 32-bit data and counter widths. With these, the 128-line bank, all four modes and both speed settings are reachable without raising any count anywhere near a wrap. A sweep of 32 configurations rotates every channel through all four groups, all four modes and window lengths from 4 to 9. It checks two consecutive windows, which shows that the boundary tick lands in exactly one window. Short directed runs exercise slow-mode gating with a line toggling faster than the tick, a clear that collides with a window end, and the mask, clear and disable sequence.

// File: rtl/awm_pkg.sv
package awm_pkg;
    localparam int CH_NUM     = 4;
    localparam int GRP_NUM    = 4;
    localparam int IDX_NUM    = 32;
    localparam int SIG_NUM    = GRP_NUM * IDX_NUM;
    localparam int SEL_W      = $clog2(SIG_NUM);
    localparam int MON_W      = 2;
    localparam int SEL_STRIDE = 8;
    localparam int MON_LSB    = 4;
    localparam int IRQ_BIT    = 2;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_WLEN = 4'h1;
    localparam logic [ADDR_W-1:0] A_SEL  = 4'h2;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] A_RES0 = 4'h8;

    typedef enum logic [MON_W-1:0] {
        MON_RISE = 2'd0,
        MON_FALL = 2'd1,
        MON_HIGH = 2'd2,
        MON_LOW  = 2'd3
    } mon_e;
endpackage

// File: rtl/awm_regs.sv
module awm_regs
    import awm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    input  logic                      win_end_i,
    input  logic [CH_NUM*CNT_W-1:0]   res_i,
    output logic                      en_o,
    output logic                      speed_o,
    output logic [CH_NUM*MON_W-1:0]   mon_o,
    output logic [CH_NUM*SEL_W-1:0]   sel_o,
    output logic [DATA_W-1:0]         wlen_o,
    output logic                      sts_o,
    output logic                      msk_o,
    output logic                      irq_o
);
    typedef struct packed {
        logic                    en;
        logic                    speed;
        logic [CH_NUM*MON_W-1:0] mon;
        logic [CH_NUM*SEL_W-1:0] sel;
        logic [DATA_W-1:0]       wlen;
        logic                    msk;
        logic                    sts;
    } regs_t;

    localparam regs_t REGS_RST = '{en: 1'b0, speed: 1'b0, mon: '0, sel: '0,
                                   wlen: '0, msk: 1'b1, sts: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (addr_i)
                A_CTRL: begin
                    r_d.en    = wdata_i[0];
                    r_d.speed = wdata_i[1];
                    r_d.mon   = wdata_i[MON_LSB +: CH_NUM*MON_W];
                end
                A_WLEN: r_d.wlen = wdata_i;
                A_SEL: begin
                    for (int c = 0; c < CH_NUM; c++) begin
                        r_d.sel[c*SEL_W +: SEL_W] = wdata_i[c*SEL_STRIDE +: SEL_W];
                    end
                end
                A_MASK: r_d.msk = wdata_i[IRQ_BIT];
                A_STAT: begin
                    if (wdata_i[IRQ_BIT]) begin
                        r_d.sts = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        // a window end outranks a simultaneous clear
        if (win_end_i) begin
            r_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[0] = r_q.en;
                rdata_o[1] = r_q.speed;
                rdata_o[MON_LSB +: CH_NUM*MON_W] = r_q.mon;
            end
            A_WLEN: rdata_o = r_q.wlen;
            A_SEL: begin
                for (int c = 0; c < CH_NUM; c++) begin
                    rdata_o[c*SEL_STRIDE +: SEL_W] = r_q.sel[c*SEL_W +: SEL_W];
                end
            end
            A_MASK: rdata_o[IRQ_BIT] = r_q.msk;
            A_STAT: rdata_o[IRQ_BIT] = r_q.sts;
            default: begin
                for (int c = 0; c < CH_NUM; c++) begin
                    if (addr_i == (A_RES0 + ADDR_W'(c))) begin
                        rdata_o = DATA_W'(res_i[c*CNT_W +: CNT_W]);
                    end
                end
            end
        endcase
    end

    assign en_o    = r_q.en;
    assign speed_o = r_q.speed;
    assign mon_o   = r_q.mon;
    assign sel_o   = r_q.sel;
    assign wlen_o  = r_q.wlen;
    assign sts_o   = r_q.sts;
    assign msk_o   = r_q.msk;
    assign irq_o   = r_q.sts & ~r_q.msk;
endmodule

// File: rtl/awm_window.sv
module awm_window #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              speed_i,
    input  logic              slow_tick_i,
    input  logic [DATA_W-1:0] wlen_i,
    output logic              tick_o,
    output logic              win_end_o
);
    logic [DATA_W-1:0] pos_d, pos_q;
    logic [DATA_W:0]   pos_nxt;
    logic              last_tick;

    assign tick_o    = en_i & (speed_i | slow_tick_i);
    assign pos_nxt   = {1'b0, pos_q} + (DATA_W+1)'(1);
    // a zero length behaves as a one-tick window
    assign last_tick = (pos_nxt >= {1'b0, wlen_i});
    assign win_end_o = tick_o & last_tick;

    always_comb begin
        pos_d = pos_q;
        if (!en_i) begin
            pos_d = '0;
        end else if (tick_o) begin
            pos_d = last_tick ? '0 : pos_nxt[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end
endmodule

// File: rtl/awm_channel.sv
module awm_channel
    import awm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               tick_i,
    input  logic               win_end_i,
    input  logic [SIG_NUM-1:0] sig_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [MON_W-1:0]   mon_i,
    output logic [CNT_W-1:0]   res_o
);
    typedef struct packed {
        logic             smp;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
    } ch_t;

    ch_t              c_d, c_q;
    logic             cur;
    logic             hit;
    logic [CNT_W-1:0] sum;

    // group and index concatenate into a flat line number
    assign cur = sig_i[sel_i];

    always_comb begin
        case (mon_i)
            MON_RISE: hit = ~c_q.smp & cur;
            MON_FALL: hit = c_q.smp & ~cur;
            MON_HIGH: hit = cur;
            default:  hit = ~cur;
        endcase
    end

    assign sum = c_q.cnt + CNT_W'(hit);

    always_comb begin
        c_d = c_q;
        if (!en_i) begin
            c_d.smp = cur;
            c_d.cnt = '0;
        end else if (tick_i) begin
            c_d.smp = cur;
            if (win_end_i) begin
                c_d.res = sum;
                c_d.cnt = '0;
            end else begin
                c_d.cnt = sum;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign res_o = c_q.res;
endmodule

// File: rtl/activity_window_monitor.sv
module activity_window_monitor
    import awm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [SIG_NUM-1:0] sig_i,
    input  logic               slow_tick_i,
    output logic               irq_o
);
    logic                    en;
    logic                    speed;
    logic [CH_NUM*MON_W-1:0] mon_bus;
    logic [CH_NUM*SEL_W-1:0] sel_bus;
    logic [DATA_W-1:0]       wlen;
    logic                    sts;
    logic                    msk;
    logic                    tick;
    logic                    win_end;
    logic [CH_NUM*CNT_W-1:0] res_bus;

    awm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .win_end_i (win_end),
        .res_i     (res_bus),
        .en_o      (en),
        .speed_o   (speed),
        .mon_o     (mon_bus),
        .sel_o     (sel_bus),
        .wlen_o    (wlen),
        .sts_o     (sts),
        .msk_o     (msk),
        .irq_o     (irq_o)
    );

    awm_window #(.DATA_W(DATA_W)) win_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en),
        .speed_i     (speed),
        .slow_tick_i (slow_tick_i),
        .wlen_i      (wlen),
        .tick_o      (tick),
        .win_end_o   (win_end)
    );

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        awm_channel #(.CNT_W(CNT_W)) ch_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (en),
            .tick_i    (tick),
            .win_end_i (win_end),
            .sig_i     (sig_i),
            .sel_i     (sel_bus[c*SEL_W +: SEL_W]),
            .mon_i     (mon_bus[c*MON_W +: MON_W]),
            .res_o     (res_bus[c*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/awm_checker.sv
module awm_checker
    import awm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    en,
    input logic                    speed,
    input logic                    slow_tick_i,
    input logic                    win_end,
    input logic                    sts,
    input logic                    msk,
    input logic                    irq_o,
    input logic [CH_NUM*CNT_W-1:0] res_bus
);
    AST_IDLE_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en |-> !win_end); // R9
    AST_END_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end |=> sts); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_end |=> $stable(res_bus)); // R6
    AST_SLOW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !speed && !slow_tick_i) |-> !win_end); // R11
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (sts && !msk)); // R8
endmodule

bind activity_window_monitor awm_checker #(.CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en          (en),
    .speed       (speed),
    .slow_tick_i (slow_tick_i),
    .win_end     (win_end),
    .sts         (sts),
    .msk         (msk),
    .irq_o       (irq_o),
    .res_bus     (res_bus)
);

// File: tb/activity_window_monitor_tb_top.sv
module activity_window_monitor_tb_top;
    localparam int CLK_PERIOD = 20;

    logic         clk;
    logic         rst_n;
    logic         reg_we;
    logic [3:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [127:0] sig;
    logic         slow_tick;
    logic         irq;

    int checks;
    int failures;
    int wl;
    logic [31:0] v;
    logic [31:0] selw;
    logic [31:0] monw;
    int sel_c [4];
    int mt_c [4];

    activity_window_monitor dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .sig_i       (sig),
        .slow_tick_i (slow_tick),
        .irq_o       (irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic bit pat(int s, int k);
        int t;
        t = k * ((s % 5) + 2) + s * 3;
        return bit'((t / ((s % 3) + 2)) % 2);
    endfunction

    task automatic set_sig(input int k);
        for (int s = 0; s < 128; s++) sig[s] = pat(s, k);
    endtask

    function automatic int expcnt(int s, int mt, int k0, int k1);
        int n;
        n = 0;
        for (int k = k0; k <= k1; k++) begin
            bit p;
            bit c;
            p = pat(s, k - 1);
            c = pat(s, k);
            case (mt)
                0: n += int'(!p && c);
                1: n += int'(p && !c);
                2: n += int'(c);
                default: n += int'(!c);
            endcase
        end
        return n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0;
        failures = 0;
        rst_n = 1'b0;
        reg_we = 1'b0;
        reg_addr = '0;
        reg_wdata = '0;
        sig = '0;
        slow_tick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        rd(4'h0, v); check("R10 ctrl", v, 0);
        rd(4'h1, v); check("R10 wlen", v, 0);
        rd(4'h2, v); check("R10 sel", v, 0);
        rd(4'h3, v); check("R10 mask", v, 4);
        rd(4'h4, v); check("R10 status", v, 0);
        for (int c = 0; c < 4; c++) begin
            rd(4'(8 + c), v); check("R10 result", v, 0);
        end
        check("R10 irq", 32'(irq), 0);

        // sweep: R1 R2 R3 R4 R5 R7 R8, fast mode
        for (int r = 0; r < 32; r++) begin
            wl = 4 + (r % 6);
            selw = '0;
            monw = '0;
            for (int c = 0; c < 4; c++) begin
                sel_c[c] = ((c + r) % 4) * 32 + ((r * 5 + c * 9) % 32);
                mt_c[c]  = (r + c) % 4;
                selw |= 32'(sel_c[c]) << (8 * c);
                monw |= 32'(mt_c[c]) << (2 * c);
            end
            wr(4'h0, 32'h0);
            wr(4'h1, 32'(wl));
            wr(4'h2, selw);
            wr(4'h3, 32'h0);
            wr(4'h4, 32'h4);
            set_sig(0);
            wr(4'h0, 32'h3 | (monw << 4));
            for (int k = 1; k <= 2 * wl + 1; k++) begin
                @(negedge clk);
                reg_we = 1'b0;
                if (k == wl + 1) begin
                    for (int c = 0; c < 4; c++) begin
                        rd(4'(8 + c), v);
                        check(mt_c[c] < 2 ? "R1 R2 R3 window1" : "R1 R2 R4 window1",
                              v, 32'(expcnt(sel_c[c], mt_c[c], 1, wl)));
                    end
                    rd(4'h4, v); check("R7 status at window end", v, 4);
                    check("R8 irq unmasked", 32'(irq), 1);
                    reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h4;
                end
                if (k == wl + 2) begin
                    rd(4'h4, v); check("R7 status cleared", v, 0);
                end
                if (k == 2 * wl + 1) begin
                    for (int c = 0; c < 4; c++) begin
                        rd(4'(8 + c), v);
                        check("R5 window2", v, 32'(expcnt(sel_c[c], mt_c[c], wl + 1, 2 * wl)));
                    end
                end
                set_sig(k);
            end
        end

        // R11 slow mode
        wr(4'h0, 32'h0);
        wr(4'h1, 32'd4);
        wr(4'h2, 32'd5 | (32'd127 << 8) | (32'd64 << 16) | (32'd64 << 24));
        wr(4'h3, 32'h0);
        wr(4'h4, 32'h4);
        sig = '0;
        sig[5] = 1'b1;
        sig[127] = 1'b1;
        monw = 32'd2 | (32'd3 << 2) | (32'd0 << 4) | (32'd1 << 6);
        wr(4'h0, 32'h1 | (monw << 4));
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            slow_tick = (k % 3 == 0);
            sig[64] = 1'(k % 2);
            if (k == 12) begin
                rd(4'h4, v); check("R11 no end before 4th tick", v, 0);
            end
            if (k == 13) begin
                rd(4'h8, v); check("R11 high ticks only", v, 4);
                rd(4'h9, v); check("R11 low level", v, 0);
                rd(4'hA, v); check("R11 rises at ticks", v, 2);
                rd(4'hB, v); check("R11 falls at ticks", v, 2);
                rd(4'h4, v); check("R11 status", v, 4);
            end
        end
        slow_tick = 1'b0;

        // R7 set over clear, R6 hold and ignored write
        wr(4'h0, 32'h0);
        wr(4'h1, 32'd3);
        wr(4'h2, 32'd5);
        wr(4'h4, 32'h4);
        wr(4'h0, 32'h3 | (32'd2 << 4));
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            reg_we = 1'b0;
            if (k == 3) begin
                reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h4;
            end
            if (k == 4) begin
                rd(4'h4, v); check("R7 end wins over clear", v, 4);
                rd(4'h8, v); check("R5 three ticks", v, 3);
                reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h0;
            end
            if (k == 5) begin
                rd(4'h4, v); check("R7 zero write", v, 4);
                reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hDEAD;
            end
            if (k == 6) begin
                rd(4'h8, v); check("R6 write ignored", v, 3);
            end
            if (k == 7) begin
                rd(4'h8, v); check("R6 next window", v, 3);
            end
        end

        // R8 mask, R9 disable
        wr(4'h0, 32'h0);
        rd(4'h4, v); check("R9 disable keeps status", v, 4);
        wr(4'h3, 32'h4);
        check("R8 masked irq", 32'(irq), 0);
        wr(4'h3, 32'h0);
        check("R8 unmasked irq", 32'(irq), 1);
        wr(4'h4, 32'h4);
        check("R8 irq after clear", 32'(irq), 0);
        repeat (20) @(negedge clk);
        rd(4'h4, v); check("R9 no window while off", v, 0);
        rd(4'h8, v); check("R9 results held", v, 3);
        check("R9 irq idle", 32'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule